// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a single-issue processor. It collects up to 32 interrupt sources and decides which one the processor should take next. It also supplies the address of that source's handler. Each source is built as one of two kinds, chosen per source by a parameter mask:

- An edge source records a rising edge in a sticky pending flag.
- A level source has no flag. It requests only while its input is high.

A request is offered only when all of these hold:

- the source's own enable is set;
- the global enable is set;
- the controller is not in the short hold that follows a return from a handler.

The processor side sees a request line and a vector address. It drives back these single-cycle strobes:

- acknowledge
- return from handler
- set global enable
- clear global enable
- instruction retired

Taking an interrupt clears the global enable, and a return sets it again. Software may set the global enable inside a handler, which allows nesting. Pending flags can be cleared by writing ones to them. A select bit moves the vector table from address zero to a boot-area base.

Top module: `irq_arbiter`

## Requirements
- R1: After synchronous reset the global enable, all pending flags, all source enables and the table select are zero, and no request is offered.
- R2: An edge source sets its pending flag on a 0-to-1 transition of its input (seen at the next clock edge). The flag stays set while its enable or the global enable is off, and is served once both are on.
- R3: A level source never sets a flag. It requests only in cycles where its input is high, and it is lost if the input falls before it is enabled.
- R4: Among enabled pending sources, the lowest index wins. The vector is base + (index+1)*2, because slot 0 belongs to reset.
- R5: An acknowledge while a request is offered clears the global enable and the winning source's flag. An acknowledge with no request offered changes nothing.
- R6: Writing the flag-clear port clears every flag whose data bit is 1 and leaves flags whose data bit is 0 alone. A rising edge in the same cycle as its clear leaves the flag set.
- R7: The return strobe and the set strobe set the global enable. The clear strobe clears it and blocks the request combinationally in the same cycle. Clear wins over set.
- R8: After a return strobe, no request is offered until one instruction-retired pulse has arrived in a later cycle.
- R9: With the table select at 1, vectors are offset by BOOT_BASE (default 0x1E00) instead of 0.
- R10: The request needs both the global enable and the source's own enable. A pending source with either one off produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Raw source conditions |
| en_we_i | input | 1 | Write strobe for the source enable register |
| en_wdata_i | input | N_SRC | New source enables |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_wdata_i | input | N_SRC | Ones clear the matching flags |
| vsel_we_i | input | 1 | Write strobe for the table select |
| vsel_wdata_i | input | 1 | 1 selects the boot-area base |
| ack_i | input | 1 | Processor takes the offered interrupt |
| reti_i | input | 1 | Return from handler |
| sei_i | input | 1 | Set global enable |
| cli_i | input | 1 | Clear global enable |
| retire_i | input | 1 | One instruction retired |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | VEC_W | Handler address of the winner |
| gie_o | output | 1 | Global enable state |
| flags_o | output | N_SRC | Pending flags |

## Verification
The assertions check several properties on every cycle:

- the winner is always pending and has no pending source of lower index;
- flags persist until they are cleared;
- an accepted acknowledge drops the global enable;
- a return raises it and blocks the following cycle;
- the clear strobe suppresses the request at once.

Some behaviours span several cycles of history, so only the bench's scenarios can show them. These include:

- masked flags being served later in priority order;
- a level request that disappears without trace;
- set winning over clear in the same cycle;
- relocated vectors;
- the exact vector values.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_SPACING = 2;
  localparam int unsigned MAX_SRC     = 32;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC      = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0,
  localparam int unsigned IW        = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic             take_i,
  input  logic [IW-1:0]    take_idx_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] pending_o
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] rise;

  assign rise = src_i & ~src_q & ~LEVEL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      flag_q <= '0;
    end else begin
      src_q <= src_i;
      for (int i = 0; i < N_SRC; i++) begin
        if (LEVEL_MASK[i]) flag_q[i] <= 1'b0;
        else if (rise[i]) flag_q[i] <= 1'b1;
        else if (clr_mask_i[i] || (take_i && take_idx_i == IW'(i))) flag_q[i] <= 1'b0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      if (LEVEL_MASK[g]) begin : g_level
        assign pending_o[g] = src_i[g];
      end else begin : g_edge
        assign pending_o[g] = flag_q[g];
        // R2: a set flag survives unless cleared by software or by being taken
        p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
          flag_q[g] && !clr_mask_i[g] && !(take_i && take_idx_i == IW'(g)) |=> flag_q[g]);
        // R6: clear without a new edge removes the flag
        p_clear_works_r6: assert property (@(posedge clk) disable iff (rst)
          clr_mask_i[g] && !rise[g] |=> !flag_q[g]);
      end
    end
  endgenerate

  assign flags_o = flag_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cand_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |cand_i;

  // R4: the winner is a candidate and nothing below it is
  p_winner_valid_r4: assert property (@(posedge clk) disable iff (rst)
    any_o |-> cand_i[idx_o]);
  p_winner_lowest_r4: assert property (@(posedge clk) disable iff (rst)
    any_o |-> ((cand_i & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0));
endmodule

// File: rtl/irq_core_ctrl.sv
module irq_core_ctrl #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we_i,
  input  logic [N_SRC-1:0] en_wdata_i,
  input  logic             vsel_we_i,
  input  logic             vsel_wdata_i,
  input  logic             take_i,
  input  logic             reti_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             retire_i,
  output logic [N_SRC-1:0] en_o,
  output logic             vsel_o,
  output logic             gie_o,
  output logic             hold_o
);
  logic [N_SRC-1:0] en_q;
  logic             vsel_q, gie_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      vsel_q <= 1'b0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (en_we_i)   en_q   <= en_wdata_i;
      if (vsel_we_i) vsel_q <= vsel_wdata_i;
      if (take_i || cli_i)       gie_q <= 1'b0;
      else if (reti_i || sei_i)  gie_q <= 1'b1;
      if (reti_i)        hold_q <= 1'b1;
      else if (retire_i) hold_q <= 1'b0;
    end
  end

  // R8: hold only releases on a retire pulse
  p_hold_release_r8: assert property (@(posedge clk) disable iff (rst)
    hold_q && !retire_i |=> hold_q);

  assign en_o   = en_q;
  assign vsel_o = vsel_q;
  assign gie_o  = gie_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC      = 8,
  parameter int unsigned VEC_W      = 16,
  parameter logic [VEC_W-1:0] BOOT_BASE = 16'h1E00,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hC0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             en_we_i,
  input  logic [N_SRC-1:0] en_wdata_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_wdata_i,
  input  logic             vsel_we_i,
  input  logic             vsel_wdata_i,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             retire_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] flags_o
);
  import irq_pkg::*;
  localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pending, en, clr_mask;
  logic [IW-1:0]    win_idx;
  logic             win_any, vsel, gie, hold, take;
  logic [VEC_W-1:0] base, slot;

  assign clr_mask = clr_we_i ? clr_wdata_i : '0;
  assign take     = ack_i && irq_req_o;

  irq_flag_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst(rst), .src_i(src_i), .clr_mask_i(clr_mask),
    .take_i(take), .take_idx_i(win_idx), .flags_o(flags_o), .pending_o(pending)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .clk(clk), .rst(rst), .cand_i(pending & en), .any_o(win_any), .idx_o(win_idx)
  );

  irq_core_ctrl #(.N_SRC(N_SRC)) u_ctrl (
    .clk(clk), .rst(rst), .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
    .vsel_we_i(vsel_we_i), .vsel_wdata_i(vsel_wdata_i), .take_i(take),
    .reti_i(reti_i), .sei_i(sei_i), .cli_i(cli_i), .retire_i(retire_i),
    .en_o(en), .vsel_o(vsel), .gie_o(gie), .hold_o(hold)
  );

  assign irq_req_o = gie && !hold && !cli_i && win_any;
  assign base      = vsel ? BOOT_BASE : '0;
  assign slot      = VEC_W'(win_idx) + VEC_W'(1);
  assign irq_vec_o = base + slot * VEC_W'(VEC_SPACING);
  assign gie_o     = gie;

  // R10: no request without global enable
  p_req_needs_gie_r10: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> gie_o);
  // R5: an accepted acknowledge drops the global enable
  p_ack_clears_gie_r5: assert property (@(posedge clk) disable iff (rst)
    ack_i && irq_req_o |=> !gie_o);
  // R7: clear strobe blocks the request in its own cycle
  p_cli_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    cli_i |-> !irq_req_o);
  // R7: return raises global enable unless cleared or taken
  p_reti_sets_gie_r7: assert property (@(posedge clk) disable iff (rst)
    reti_i && !cli_i && !(ack_i && irq_req_o) |=> gie_o);
  // R8: the cycle after a return offers nothing
  p_reti_hold_r8: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> !irq_req_o);
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] src = '0, en_wd = '0, clr_wd = '0;
  logic en_we = 0, clr_we = 0, vsel_we = 0, vsel_wd = 0;
  logic ack = 0, reti = 0, sei = 0, cli = 0, ret = 0;
  logic req, gie;
  logic [15:0] vec;
  logic [7:0] flags;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst(rst), .src_i(src), .en_we_i(en_we), .en_wdata_i(en_wd),
    .clr_we_i(clr_we), .clr_wdata_i(clr_wd), .vsel_we_i(vsel_we), .vsel_wdata_i(vsel_wd),
    .ack_i(ack), .reti_i(reti), .sei_i(sei), .cli_i(cli), .retire_i(ret),
    .irq_req_o(req), .irq_vec_o(vec), .gie_o(gie), .flags_o(flags)
  );

  typedef struct packed {
    logic [7:0] src; logic en_we; logic [7:0] en; logic [7:0] clr;
    logic ack, reti, sei, cli, ret;
    logic x_req; logic [15:0] x_vec; logic x_gie; logic [7:0] x_fl; logic [3:0] tag;
  } step_t;

  localparam int NSTEP = 20;
  localparam step_t STEPS [NSTEP] = '{
    //  src  we en     clr   a r s c t  req vec    gie flags tag
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h00,4'd1},  // R1
    '{8'h04,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h00,4'd2},
    '{8'h04,1'b1,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h04,4'd2},  // R2 flag latched while masked
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h04,4'd10}, // R10 gie off
    '{8'h01,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0006,1'b1,8'h04,4'd2},  // R2 served later
    '{8'h00,1'b0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0002,1'b1,8'h05,4'd4},  // R4 lowest wins
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h04,4'd5},  // R5 ack clears
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,16'h0000,1'b1,8'h04,4'd8},  // R8 hold
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0006,1'b1,8'h04,4'd8},  // R8 released
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,16'h0000,1'b1,8'h04,4'd7},  // R7 cli same cycle
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h04,4'd7},  // R7 cli cleared gie
    '{8'h80,1'b0,8'h00,8'h04,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0006,1'b1,8'h04,4'd7},  // R7 sei sets
    '{8'h80,1'b1,8'h7F,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0010,1'b1,8'h00,4'd3},  // R3 level, R6 clear
    '{8'h80,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b1,8'h00,4'd10}, // R10 own enable off
    '{8'h00,1'b1,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b1,8'h00,4'd3},
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b1,8'h00,4'd3},  // R3 level lost
    '{8'h02,1'b0,8'h00,8'h02,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b1,8'h00,4'd6},
    '{8'h00,1'b0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,16'h0004,1'b1,8'h02,4'd6},  // R6 set beats clear
    '{8'h10,1'b0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h00,4'd5},  // R5 taken
    '{8'h00,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'h0000,1'b0,8'h10,4'd5}   // R5 idle ack ignored
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_in();
    src = '0; en_we = 0; en_wd = '0; clr_we = 0; clr_wd = '0; vsel_we = 0; vsel_wd = 0;
    ack = 0; reti = 0; sei = 0; cli = 0; ret = 0;
  endtask

  initial begin
    clear_in();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    chk("R1", "req", 32'(req), 0);
    chk("R1", "gie", 32'(gie), 0);
    chk("R1", "flags", 32'(flags), 0);

    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      src = STEPS[k].src; en_we = STEPS[k].en_we; en_wd = STEPS[k].en;
      clr_we = |STEPS[k].clr; clr_wd = STEPS[k].clr;
      ack = STEPS[k].ack; reti = STEPS[k].reti; sei = STEPS[k].sei;
      cli = STEPS[k].cli; ret = STEPS[k].ret;
      #1;
      chk($sformatf("R%0d", STEPS[k].tag), $sformatf("step%0d req", k), 32'(req), 32'(STEPS[k].x_req));
      chk($sformatf("R%0d", STEPS[k].tag), $sformatf("step%0d gie", k), 32'(gie), 32'(STEPS[k].x_gie));
      chk($sformatf("R%0d", STEPS[k].tag), $sformatf("step%0d flags", k), 32'(flags), 32'(STEPS[k].x_fl));
      if (STEPS[k].x_req)
        chk($sformatf("R%0d", STEPS[k].tag), $sformatf("step%0d vec", k), 32'(vec), 32'(STEPS[k].x_vec));
    end

    // R9: relocate table, flag 4 pending, enables all on
    @(negedge clk);
    clear_in(); vsel_we = 1; vsel_wd = 1; sei = 1;
    @(negedge clk);
    clear_in();
    #1;
    chk("R9", "req", 32'(req), 1);
    chk("R9", "vec", 32'(vec), 32'h1E0A);

    // R1: reset mid-run wipes state
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    #1;
    chk("R1", "req after reset", 32'(req), 0);
    chk("R1", "gie after reset", 32'(gie), 0);
    chk("R1", "flags after reset", 32'(flags), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule